// File: doc/BRIEF.md
# Accumulator Shift and Saturate Stage

This stage sits behind the ALU of a fixed-point audio datapath. It accepts a 34-bit accumulator word, which is a 30-bit signed working range with 4 guard bits above it. It shifts the word by one of a small set of amounts, left or right. It then hands a 24-bit word to the data bus. The bus word is the shifted value's bits 29 down to 6. When the shifted value no longer fits the 30-bit signed range, the stage replaces it with the full-scale value of the matching sign and raises an overflow flag.

The shift amount comes from a 3-bit code in the instruction, or indirectly from a 4-bit register value when the indirect select is high. An amount that the chosen direction does not support is not applied. The stage then passes the word through unshifted and raises an error flag. The stage is registered: each accepted input appears at the outputs one clock later.

Top module: `accsh_unit`

## Requirements
- R1: A word presented with `in_valid` high appears on the outputs with `out_valid` high exactly one clock edge later.
- R2: With `use_ind` low, `shift_code` selects the amount: code 0→0, 1→1, 2→2, 3→3, 4→4, 5→6, 6→8, 7→15 bits. `dir_left`=1 shifts left and `dir_left`=0 shifts right.
- R3: Right shifts are arithmetic. The output is bit 29 down to bit 6 of the shifted value, with the lower bits truncated toward minus infinity.
- R4: With any shift, including none, the result is saturated unless the shifted value lies in [-2^29, 2^29-1]. This range check covers the guard bits.
- R5: On saturation the output is 0x7FFFFF for a positive value and 0x800000 for a negative value, and `out_ovf` is high for that result.
- R6: A right shift with code 5 (6 bits) is illegal. The word passes unshifted and `out_err` is high.
- R7: With `use_ind` high, `ind_amt` gives the amount in bits and `shift_code` is ignored. Legal left amounts are 0,1,2,3,4,6,8,15. Legal right amounts are 0,1,2,3,4,8,15.
- R8: An indirect amount outside the legal set for the direction yields zero shift and `out_err` high. Saturation of the unshifted word still applies.
- R9: When `in_valid` is low, `out_valid`, `out_ovf` and `out_err` go low the next cycle, and `out_data` holds its last value.
- R10: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word strobe |
| acc_in | input | 34 | Accumulator word, two's complement |
| dir_left | input | 1 | 1 = shift left, 0 = shift right |
| shift_code | input | 3 | Immediate amount code |
| use_ind | input | 1 | Take amount from `ind_amt` |
| ind_amt | input | 4 | Indirect shift amount in bits |
| out_valid | output | 1 | Result strobe |
| out_data | output | 24 | Bus word |
| out_ovf | output | 1 | Result was saturated |
| out_err | output | 1 | Requested amount was illegal |

## Verification
The bench probes both edges of the 30-bit window. The most negative fitting value must pass as 0x800000 without a flag, and one step beyond it must saturate. A design that checked only the top guard bit, or clamped symmetrically, would flag the first case or miss the second. Right shifts of small negative words must give all-ones. A logical shift or a round-toward-zero would give zero instead. Illegal amounts are sent both directly (right by 6) and indirectly, including one that overflows unshifted. A design that applied the nearest legal shift, or suppressed saturation on error, would produce a scaled word or a wrapped one.

// File: rtl/accsh_pkg.sv
package accsh_pkg;
   localparam int unsigned CODE_W    = 3;
   localparam int unsigned NUM_CODES = 1 << CODE_W;
   localparam int unsigned MAX_SHIFT = 15;
   localparam logic [CODE_W-1:0] CODE_SIX = 3'd5;

   function automatic int unsigned code_amount(input int unsigned c);
      case (c)
         0: return 0;
         1: return 1;
         2: return 2;
         3: return 3;
         4: return 4;
         5: return 6;
         6: return 8;
         default: return 15;
      endcase
   endfunction
endpackage

// File: rtl/accsh_decode.sv
module accsh_decode
   import accsh_pkg::*;
#(
   parameter int unsigned IND_W = 4
) (
   input  logic              dir_left,
   input  logic [CODE_W-1:0] shift_code,
   input  logic              use_ind,
   input  logic [IND_W-1:0]  ind_amt,
   output logic [CODE_W-1:0] sel_code,
   output logic              illegal
);
   logic [CODE_W-1:0] ind_code;
   logic              ind_bad;
   logic [CODE_W-1:0] raw_code;

   always_comb begin
      ind_bad  = 1'b0;
      ind_code = '0;
      case (ind_amt)
         IND_W'(0):  ind_code = 3'd0;
         IND_W'(1):  ind_code = 3'd1;
         IND_W'(2):  ind_code = 3'd2;
         IND_W'(3):  ind_code = 3'd3;
         IND_W'(4):  ind_code = 3'd4;
         IND_W'(6):  ind_code = 3'd5;
         IND_W'(8):  ind_code = 3'd6;
         IND_W'(15): ind_code = 3'd7;
         default:    ind_bad  = 1'b1;
      endcase
   end

   always_comb begin
      raw_code = use_ind ? ind_code : shift_code;
      illegal  = (use_ind & ind_bad) | (~dir_left & (raw_code == CODE_SIX));
      sel_code = illegal ? '0 : raw_code;
   end
endmodule

// File: rtl/accsh_shift.sv
module accsh_shift
   import accsh_pkg::*;
#(
   parameter int unsigned ACC_W = 34,
   parameter int unsigned EXT_W = ACC_W + MAX_SHIFT
) (
   input  logic [ACC_W-1:0]  acc,
   input  logic              dir_left,
   input  logic [CODE_W-1:0] sel_code,
   output logic [EXT_W-1:0]  shifted
);
   logic signed [EXT_W-1:0] ext_s;
   logic [EXT_W-1:0] cand_l [NUM_CODES];
   logic [EXT_W-1:0] cand_r [NUM_CODES];

   assign ext_s = $signed({{(EXT_W-ACC_W){acc[ACC_W-1]}}, acc});

   for (genvar g = 0; g < NUM_CODES; g++) begin : g_amt
      localparam int unsigned AMT = code_amount(g);
      assign cand_l[g] = ext_s <<< AMT;
      assign cand_r[g] = ext_s >>> AMT;
   end

   assign shifted = dir_left ? cand_l[sel_code] : cand_r[sel_code];
endmodule

// File: rtl/accsh_sat.sv
module accsh_sat #(
   parameter int unsigned EXT_W   = 49,
   parameter int unsigned OUT_W   = 24,
   parameter int unsigned LSB_POS = 6
) (
   input  logic [EXT_W-1:0] wide,
   output logic [OUT_W-1:0] data,
   output logic             ovf
);
   localparam int unsigned MSB_POS = OUT_W + LSB_POS - 1;
   localparam logic [OUT_W-1:0] POS_FULL = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] NEG_FULL = {1'b1, {(OUT_W-1){1'b0}}};

   logic [EXT_W-1:MSB_POS] upper;
   logic fits;

   assign upper = wide[EXT_W-1:MSB_POS];
   assign fits  = (&upper) | ~(|upper);
   assign ovf   = ~fits;
   assign data  = fits ? wide[MSB_POS:LSB_POS]
                       : (wide[EXT_W-1] ? NEG_FULL : POS_FULL);
endmodule

// File: rtl/accsh_unit.sv
module accsh_unit
   import accsh_pkg::*;
#(
   parameter int unsigned ACC_W   = 34,
   parameter int unsigned GUARD_W = 4,
   parameter int unsigned OUT_W   = 24,
   parameter int unsigned IND_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ACC_W-1:0]  acc_in,
   input  logic              dir_left,
   input  logic [CODE_W-1:0] shift_code,
   input  logic              use_ind,
   input  logic [IND_W-1:0]  ind_amt,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_data,
   output logic              out_ovf,
   output logic              out_err
);
   localparam int unsigned LSB_POS = ACC_W - GUARD_W - OUT_W;
   localparam int unsigned MSB_POS = OUT_W + LSB_POS - 1;
   localparam int unsigned EXT_W   = ACC_W + MAX_SHIFT;

   if (ACC_W <= GUARD_W + OUT_W) begin : g_bad_width
      $error("accsh_unit: ACC_W must exceed GUARD_W + OUT_W");
   end
   if (IND_W < 4) begin : g_bad_ind
      $error("accsh_unit: IND_W must hold amount 15");
   end

   logic [CODE_W-1:0] sel_code;
   logic              illegal;
   logic [EXT_W-1:0]  shifted;
   logic [OUT_W-1:0]  sat_data;
   logic              sat_ovf;

   accsh_decode #(.IND_W(IND_W)) u_dec (
      .dir_left  (dir_left),
      .shift_code(shift_code),
      .use_ind   (use_ind),
      .ind_amt   (ind_amt),
      .sel_code  (sel_code),
      .illegal   (illegal)
   );

   accsh_shift #(.ACC_W(ACC_W), .EXT_W(EXT_W)) u_shf (
      .acc     (acc_in),
      .dir_left(dir_left),
      .sel_code(sel_code),
      .shifted (shifted)
   );

   accsh_sat #(.EXT_W(EXT_W), .OUT_W(OUT_W), .LSB_POS(LSB_POS)) u_sat (
      .wide(shifted),
      .data(sat_data),
      .ovf (sat_ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_ovf   <= 1'b0;
         out_err   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_ovf   <= in_valid & sat_ovf;
         out_err   <= in_valid & illegal;
         if (in_valid) out_data <= sat_data;
      end
   end

   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_sat_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovf |-> (out_data == {1'b0, {(OUT_W-1){1'b1}}} ||
                   out_data == {1'b1, {(OUT_W-1){1'b0}}}));

   p_err_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && use_ind && !dir_left && ind_amt == IND_W'(5)) |=>
         (out_err && (out_ovf || out_data == $past(acc_in[MSB_POS:LSB_POS]))));

   p_flag_qual_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ovf || out_err) |-> out_valid);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_data)));
endmodule

// File: tb/accsh_unit_test.sv
module accsh_unit_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [33:0] acc_in;
   logic        dir_left;
   logic [2:0]  shift_code;
   logic        use_ind;
   logic [3:0]  ind_amt;
   logic        out_valid;
   logic [23:0] out_data;
   logic        out_ovf;
   logic        out_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   accsh_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_in(acc_in),
      .dir_left(dir_left), .shift_code(shift_code), .use_ind(use_ind),
      .ind_amt(ind_amt), .out_valid(out_valid), .out_data(out_data),
      .out_ovf(out_ovf), .out_err(out_err)
   );

   typedef struct packed {
      logic [33:0] acc;
      logic        left;
      logic [2:0]  code;
      logic        ind;
      logic [3:0]  amt;
      logic [23:0] exp_d;
      logic        exp_o;
      logic        exp_e;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [0:NV-1] = '{
      '{34'h0_0000_0040, 1'b0, 3'd0, 1'b0, 4'd0,  24'h000001, 1'b0, 1'b0, 8'd3}, // R3 no shift
      '{34'h0_0000_0040, 1'b1, 3'd1, 1'b0, 4'd0,  24'h000002, 1'b0, 1'b0, 8'd2}, // R2 left 1
      '{34'h0_0000_0040, 1'b1, 3'd5, 1'b0, 4'd0,  24'h000040, 1'b0, 1'b0, 8'd2}, // R2 left 6
      '{34'h0_0123_4500, 1'b1, 3'd7, 1'b0, 4'd0,  24'h7FFFFF, 1'b1, 1'b0, 8'd5}, // R5 left 15 clip
      '{34'h3_FFFF_FFC0, 1'b0, 3'd1, 1'b0, 4'd0,  24'hFFFFFF, 1'b0, 1'b0, 8'd3}, // R3 floor
      '{34'h2_0000_0000, 1'b0, 3'd7, 1'b0, 4'd0,  24'hFFF000, 1'b0, 1'b0, 8'd3}, // R3 right 15
      '{34'h2_0000_0000, 1'b0, 3'd6, 1'b0, 4'd0,  24'hF80000, 1'b0, 1'b0, 8'd2}, // R2 right 8
      '{34'h0_2000_0000, 1'b0, 3'd0, 1'b0, 4'd0,  24'h7FFFFF, 1'b1, 1'b0, 8'd4}, // R4 guard
      '{34'h3_E000_0000, 1'b0, 3'd0, 1'b0, 4'd0,  24'h800000, 1'b0, 1'b0, 8'd4}, // R4 min fits
      '{34'h0_1FFF_FFFF, 1'b0, 3'd0, 1'b0, 4'd0,  24'h7FFFFF, 1'b0, 1'b0, 8'd4}, // R4 max fits
      '{34'h3_FE00_0000, 1'b1, 3'd4, 1'b0, 4'd0,  24'h800000, 1'b0, 1'b0, 8'd4}, // R4 left edge
      '{34'h3_FDFF_FFFF, 1'b1, 3'd4, 1'b0, 4'd0,  24'h800000, 1'b1, 1'b0, 8'd5}, // R5 neg clip
      '{34'h0_1000_0000, 1'b1, 3'd1, 1'b0, 4'd0,  24'h7FFFFF, 1'b1, 1'b0, 8'd5}, // R5 pos clip
      '{34'h0_0000_0100, 1'b0, 3'd5, 1'b0, 4'd0,  24'h000004, 1'b0, 1'b1, 8'd6}, // R6 right 6
      '{34'h0_0000_0040, 1'b1, 3'd7, 1'b1, 4'd8,  24'h000100, 1'b0, 1'b0, 8'd7}, // R7 ind 8
      '{34'h0_7FFF_8000, 1'b0, 3'd1, 1'b1, 4'd15, 24'h0003FF, 1'b0, 1'b0, 8'd7}, // R7 ind 15
      '{34'h0_0000_0080, 1'b1, 3'd7, 1'b1, 4'd5,  24'h000002, 1'b0, 1'b1, 8'd8}, // R8 ind 5
      '{34'h0_0000_0100, 1'b0, 3'd2, 1'b1, 4'd6,  24'h000004, 1'b0, 1'b1, 8'd8}, // R8 ind 6 right
      '{34'h0_2000_0000, 1'b1, 3'd1, 1'b1, 4'd9,  24'h7FFFFF, 1'b1, 1'b1, 8'd8}, // R8 err+clip
      '{34'h0_0000_0040, 1'b0, 3'd7, 1'b1, 4'd0,  24'h000001, 1'b0, 1'b0, 8'd7}  // R7 ind 0
   };

   task automatic check(input string tag, input logic [26:0] act, input logic [26:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b1; acc_in = 34'h0_2000_0000;
      dir_left = 1'b0; shift_code = '0; use_ind = 1'b0; ind_amt = '0;
      repeat (3) @(negedge clk);
      // R10: reset clears everything despite in_valid
      check("R10 reset", {out_valid, out_data, out_ovf, out_err}, 27'd0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NV; i++) begin
         acc_in = VECS[i].acc; dir_left = VECS[i].left;
         shift_code = VECS[i].code; use_ind = VECS[i].ind;
         ind_amt = VECS[i].amt; in_valid = 1'b1;
         @(negedge clk);
         // R1: result visible one edge later
         check($sformatf("R1/R%0d vec %0d", VECS[i].req, i),
               {out_valid, out_data, out_ovf, out_err},
               {1'b1, VECS[i].exp_d, VECS[i].exp_o, VECS[i].exp_e});
      end
      // R9: idle input keeps data, drops strobe and flags
      in_valid = 1'b0; acc_in = 34'h0_2000_0000; use_ind = 1'b1; ind_amt = 4'd5;
      @(negedge clk);
      check("R9 idle hold", {out_valid, out_data, out_ovf, out_err},
            {1'b0, 24'h000001, 1'b0, 1'b0});
      @(negedge clk);
      check("R9 idle hold 2", {out_valid, out_data, out_ovf, out_err},
            {1'b0, 24'h000001, 1'b0, 1'b0});
      // R1: single valid then idle, strobe lasts one cycle
      in_valid = 1'b1; use_ind = 1'b0; acc_in = 34'h0_0000_00C0; dir_left = 1'b1; shift_code = 3'd2;
      @(negedge clk);
      in_valid = 1'b0;
      check("R1 single", {out_valid, out_data, out_ovf, out_err},
            {1'b1, 24'h00000C, 1'b0, 1'b0});
      @(negedge clk);
      check("R1 strobe drop", {26'd0, out_valid}, 27'd0);
      // R10: reset mid-stream clears held data
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 reset again", {out_valid, out_data, out_ovf, out_err}, 27'd0);
      rst_n = 1'b1;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule